// File: doc/BRIEF.md
# RC Mesh Node Euler-Step Pipeline

This block advances one node of a rectangular resistor-capacitor power mesh by a single forward-Euler time step. It accepts a new node every clock. Each node brings its own voltage, the voltages of its right and lower neighbours, and its stored charge. It also brings conductances toward the right and downward, a reciprocal capacitance and a load current. The last two inputs are the currents that its left and upper neighbours already pushed toward it. The block returns the node's two outflow currents, the new charge and the new voltage. It also returns the node's row and column, so that a surrounding sequencer can write the results back.

All arithmetic is signed 32-bit fixed point with 22 fractional bits. The block has no divider. Currents come from multiplying a voltage difference by a stored conductance, and voltage comes from multiplying charge by a stored reciprocal capacitance. Every product is shifted back to the 22-bit fraction, and every sum saturates rather than wraps.

The block finds mesh edges from the node's indices. On the right or bottom edge, the absent neighbour's voltage is replaced by the node's own voltage, so no current crosses the open side. On the left or top edge, the absent inflow is replaced by zero.

Top module: `rcmesh_node_pipe`

## Requirements
- R1: A node presented with `in_valid_i` high at a rising edge appears with `out_valid_o` high exactly 8 rising edges later. Its row and column come out unchanged. A new node may be presented at every edge.
- R2: `i_right_o` equals sat((sat(v_self − v_right) × g_right) >>> 22), where >>> is an arithmetic shift that truncates and sat clamps to the signed 32-bit range.
- R3: `i_down_o` equals sat((sat(v_self − v_down) × g_down) >>> 22).
- R4: When the column index is NUM_COLS−1, `v_right_i` is ignored and the node's own voltage is used in its place, so `i_right_o` is 0. When the row index is NUM_ROWS−1, the same rule applies to `v_down_i` and `i_down_o`.
- R5: When the column index is 0, `i_left_in_i` is ignored and taken as 0. When the row index is 0, `i_up_in_i` is ignored and taken as 0.
- R6: `q_next_o` equals sat(q_prev + dq). Here dq = sat((sat(sat(i_left + i_up − i_right − i_down) − i_load) × DT_FX) >>> 22), and DT_FX is the time-step parameter in Q22.
- R7: `v_next_o` equals sat((q_next × inv_cap) >>> 22).
- R8: Any difference, sum or rescaled product that leaves the signed 32-bit range clamps to 0x7FFFFFFF if positive or 0x80000000 if negative. It never wraps.
- R9: While `rst_ni` is low, `out_valid_o` is 0 and all data outputs are 0.
- R10: A cycle with `in_valid_i` low produces a cycle with `out_valid_o` low exactly 8 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Node operands valid this cycle |
| in_row_i | input | ROW_W | Node row index |
| in_col_i | input | COL_W | Node column index |
| v_self_i | input | DATA_W | Node voltage |
| v_right_i | input | DATA_W | Right neighbour voltage |
| v_down_i | input | DATA_W | Lower neighbour voltage |
| q_prev_i | input | DATA_W | Stored node charge |
| g_right_i | input | DATA_W | Conductance to the right neighbour |
| g_down_i | input | DATA_W | Conductance to the lower neighbour |
| inv_cap_i | input | DATA_W | Reciprocal of node capacitance |
| i_load_i | input | DATA_W | Load current drawn at the node |
| i_left_in_i | input | DATA_W | Outflow of left neighbour toward this node |
| i_up_in_i | input | DATA_W | Outflow of upper neighbour toward this node |
| out_valid_o | output | 1 | Results valid |
| out_row_o | output | ROW_W | Row index of the result |
| out_col_o | output | COL_W | Column index of the result |
| i_right_o | output | DATA_W | Rightward outflow current |
| i_down_o | output | DATA_W | Downward outflow current |
| q_next_o | output | DATA_W | Updated charge |
| v_next_o | output | DATA_W | Updated voltage |

## Verification
The bench walks every node of a 3×4 mesh under five stimulus sets. A flat mesh with no inflow or load leaves the charge unchanged, which exposes sign or offset errors. A graded mesh with distinct right and down conductances separates the two branch paths and catches swapped operands. A pseudo-random set exercises the truncating shifts on odd fractions. Two extreme sets, one positive and one negative, push every difference, product and sum into both saturation limits. Bubbles between the sets, together with deliberately wrong neighbour values at the edges, show whether edge substitution and valid alignment depend on the indices and not on the data.

// File: rtl/rcmesh_pkg.sv
package rcmesh_pkg;

    localparam int unsigned RCM_NSTG = 8;

    localparam int RCM_S_CAPT  = 0;
    localparam int RCM_S_DIFF  = 1;
    localparam int RCM_S_CURR  = 2;
    localparam int RCM_S_BRSUM = 3;
    localparam int RCM_S_LOAD  = 4;
    localparam int RCM_S_STEP  = 5;
    localparam int RCM_S_CHRG  = 6;

    localparam int RCM_DIR_RIGHT = 0;
    localparam int RCM_DIR_DOWN  = 1;
    localparam int RCM_NDIR      = 2;

endpackage

// File: rtl/rcmesh_fx_mul.sv
module rcmesh_fx_mul #(
    parameter int W = 32,
    parameter int F = 22
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    localparam int PW = 2 * W;
    localparam logic signed [W-1:0] FX_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] FX_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shft;
    logic                 ovf;

    always_comb begin
        prod = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
        shft = prod >>> F;
        ovf  = (shft[PW-1:W-1] != {(PW-W+1){shft[PW-1]}});
        if (ovf) y_o = shft[PW-1] ? FX_MIN : FX_MAX;
        else     y_o = shft[W-1:0];
    end
endmodule

// File: rtl/rcmesh_fx_add.sv
module rcmesh_fx_add #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic                sub_i,
    output logic signed [W-1:0] y_o
);
    localparam int XW = W + 2;
    localparam logic signed [W-1:0] FX_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] FX_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [XW-1:0] ax;
    logic signed [XW-1:0] bx;
    logic signed [XW-1:0] sx;
    logic                 ovf;

    always_comb begin
        ax  = $signed({{2{a_i[W-1]}}, a_i});
        bx  = $signed({{2{b_i[W-1]}}, b_i});
        sx  = sub_i ? (ax - bx) : (ax + bx);
        ovf = (sx[XW-1:W-1] != {(XW-W+1){sx[XW-1]}});
        if (ovf) y_o = sx[XW-1] ? FX_MIN : FX_MAX;
        else     y_o = sx[W-1:0];
    end
endmodule

// File: rtl/rcmesh_edge_sel.sv
module rcmesh_edge_sel #(
    parameter int W = 32
) (
    input  logic          missing_i,
    input  logic [W-1:0]  nb_i,
    input  logic [W-1:0]  fill_i,
    output logic [W-1:0]  y_o
);
    always_comb y_o = missing_i ? fill_i : nb_i;
endmodule

// File: rtl/rcmesh_node_pipe.sv
module rcmesh_node_pipe #(
    parameter int NUM_ROWS = 64,
    parameter int NUM_COLS = 64,
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 22,
    parameter logic signed [DATA_W-1:0] DT_FX = 41943,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     in_valid_i,
    input  logic [ROW_W-1:0]         in_row_i,
    input  logic [COL_W-1:0]         in_col_i,
    input  logic signed [DATA_W-1:0] v_self_i,
    input  logic signed [DATA_W-1:0] v_right_i,
    input  logic signed [DATA_W-1:0] v_down_i,
    input  logic signed [DATA_W-1:0] q_prev_i,
    input  logic signed [DATA_W-1:0] g_right_i,
    input  logic signed [DATA_W-1:0] g_down_i,
    input  logic signed [DATA_W-1:0] inv_cap_i,
    input  logic signed [DATA_W-1:0] i_load_i,
    input  logic signed [DATA_W-1:0] i_left_in_i,
    input  logic signed [DATA_W-1:0] i_up_in_i,
    output logic                     out_valid_o,
    output logic [ROW_W-1:0]         out_row_o,
    output logic [COL_W-1:0]         out_col_o,
    output logic signed [DATA_W-1:0] i_right_o,
    output logic signed [DATA_W-1:0] i_down_o,
    output logic signed [DATA_W-1:0] q_next_o,
    output logic signed [DATA_W-1:0] v_next_o
);
    import rcmesh_pkg::*;

    localparam int NMID = RCM_NSTG - 1;
    localparam int SW   = DATA_W + 2;
    localparam logic signed [DATA_W-1:0] FX_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] FX_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    typedef logic signed [DATA_W-1:0] fx_t;

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        fx_t              v;
        fx_t              vr;
        fx_t              vd;
        fx_t              gr;
        fx_t              gd;
        fx_t              z;
        fx_t              q;
        fx_t              il;
        fx_t              iu;
        fx_t              ild;
        fx_t              dr;
        fx_t              dd;
        fx_t              ir;
        fx_t              id;
        fx_t              net;
        fx_t              dq;
        fx_t              qn;
    } stage_t;

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        fx_t              ir;
        fx_t              id;
        fx_t              qn;
        fx_t              vn;
    } res_t;

    stage_t pipe_d [NMID];
    stage_t pipe_q [NMID];
    res_t   res_d;
    res_t   res_q;

    // edge substitution at capture: 0 right V, 1 down V, 2 left I, 3 up I
    logic       sel_miss [4];
    fx_t        sel_nb   [4];
    fx_t        sel_fill [4];
    fx_t        sel_y    [4];

    always_comb begin
        sel_miss[0] = (in_col_i == COL_LAST);
        sel_nb[0]   = v_right_i;
        sel_fill[0] = v_self_i;
        sel_miss[1] = (in_row_i == ROW_LAST);
        sel_nb[1]   = v_down_i;
        sel_fill[1] = v_self_i;
        sel_miss[2] = (in_col_i == '0);
        sel_nb[2]   = i_left_in_i;
        sel_fill[2] = '0;
        sel_miss[3] = (in_row_i == '0);
        sel_nb[3]   = i_up_in_i;
        sel_fill[3] = '0;
    end

    for (genvar e = 0; e < 4; e++) begin : g_edge
        rcmesh_edge_sel #(.W(DATA_W)) u_sel (
            .missing_i (sel_miss[e]),
            .nb_i      (sel_nb[e]),
            .fill_i    (sel_fill[e]),
            .y_o       (sel_y[e])
        );
    end

    // per-direction potential difference and branch current
    fx_t dif_nb  [RCM_NDIR];
    fx_t dif_y   [RCM_NDIR];
    fx_t cur_dv  [RCM_NDIR];
    fx_t cur_g   [RCM_NDIR];
    fx_t cur_y   [RCM_NDIR];

    always_comb begin
        dif_nb[RCM_DIR_RIGHT] = pipe_q[RCM_S_CAPT].vr;
        dif_nb[RCM_DIR_DOWN]  = pipe_q[RCM_S_CAPT].vd;
        cur_dv[RCM_DIR_RIGHT] = pipe_q[RCM_S_DIFF].dr;
        cur_dv[RCM_DIR_DOWN]  = pipe_q[RCM_S_DIFF].dd;
        cur_g[RCM_DIR_RIGHT]  = pipe_q[RCM_S_DIFF].gr;
        cur_g[RCM_DIR_DOWN]   = pipe_q[RCM_S_DIFF].gd;
    end

    for (genvar d = 0; d < RCM_NDIR; d++) begin : g_dir
        rcmesh_fx_add #(.W(DATA_W)) u_diff (
            .a_i   (pipe_q[RCM_S_CAPT].v),
            .b_i   (dif_nb[d]),
            .sub_i (1'b1),
            .y_o   (dif_y[d])
        );
        rcmesh_fx_mul #(.W(DATA_W), .F(FRAC_W)) u_cur (
            .a_i (cur_dv[d]),
            .b_i (cur_g[d]),
            .y_o (cur_y[d])
        );
    end

    fx_t load_y;
    fx_t step_y;
    fx_t chrg_y;
    fx_t volt_y;

    rcmesh_fx_add #(.W(DATA_W)) u_load (
        .a_i   (pipe_q[RCM_S_BRSUM].net),
        .b_i   (pipe_q[RCM_S_BRSUM].ild),
        .sub_i (1'b1),
        .y_o   (load_y)
    );

    rcmesh_fx_mul #(.W(DATA_W), .F(FRAC_W)) u_step (
        .a_i (pipe_q[RCM_S_LOAD].net),
        .b_i (DT_FX),
        .y_o (step_y)
    );

    rcmesh_fx_add #(.W(DATA_W)) u_chrg (
        .a_i   (pipe_q[RCM_S_STEP].q),
        .b_i   (pipe_q[RCM_S_STEP].dq),
        .sub_i (1'b0),
        .y_o   (chrg_y)
    );

    rcmesh_fx_mul #(.W(DATA_W), .F(FRAC_W)) u_volt (
        .a_i (pipe_q[RCM_S_CHRG].qn),
        .b_i (pipe_q[RCM_S_CHRG].z),
        .y_o (volt_y)
    );

    // four-branch balance: inflows minus outflows, one wide sum then clamp
    logic signed [SW-1:0] br_wide;
    fx_t                  br_sat;

    always_comb begin
        br_wide = $signed({{2{pipe_q[RCM_S_CURR].il[DATA_W-1]}}, pipe_q[RCM_S_CURR].il})
                + $signed({{2{pipe_q[RCM_S_CURR].iu[DATA_W-1]}}, pipe_q[RCM_S_CURR].iu})
                - $signed({{2{pipe_q[RCM_S_CURR].ir[DATA_W-1]}}, pipe_q[RCM_S_CURR].ir})
                - $signed({{2{pipe_q[RCM_S_CURR].id[DATA_W-1]}}, pipe_q[RCM_S_CURR].id});
        if (br_wide[SW-1:DATA_W-1] != {(SW-DATA_W+1){br_wide[SW-1]}})
            br_sat = br_wide[SW-1] ? FX_MIN : FX_MAX;
        else
            br_sat = br_wide[DATA_W-1:0];
    end

    // next-state of every stage
    always_comb begin
        pipe_d[RCM_S_CAPT]     = '0;
        pipe_d[RCM_S_CAPT].vld = in_valid_i;
        pipe_d[RCM_S_CAPT].row = in_row_i;
        pipe_d[RCM_S_CAPT].col = in_col_i;
        pipe_d[RCM_S_CAPT].v   = v_self_i;
        pipe_d[RCM_S_CAPT].vr  = sel_y[0];
        pipe_d[RCM_S_CAPT].vd  = sel_y[1];
        pipe_d[RCM_S_CAPT].il  = sel_y[2];
        pipe_d[RCM_S_CAPT].iu  = sel_y[3];
        pipe_d[RCM_S_CAPT].gr  = g_right_i;
        pipe_d[RCM_S_CAPT].gd  = g_down_i;
        pipe_d[RCM_S_CAPT].z   = inv_cap_i;
        pipe_d[RCM_S_CAPT].q   = q_prev_i;
        pipe_d[RCM_S_CAPT].ild = i_load_i;

        for (int k = 1; k < NMID; k++) pipe_d[k] = pipe_q[k-1];

        pipe_d[RCM_S_DIFF].dr   = dif_y[RCM_DIR_RIGHT];
        pipe_d[RCM_S_DIFF].dd   = dif_y[RCM_DIR_DOWN];
        pipe_d[RCM_S_CURR].ir   = cur_y[RCM_DIR_RIGHT];
        pipe_d[RCM_S_CURR].id   = cur_y[RCM_DIR_DOWN];
        pipe_d[RCM_S_BRSUM].net = br_sat;
        pipe_d[RCM_S_LOAD].net  = load_y;
        pipe_d[RCM_S_STEP].dq   = step_y;
        pipe_d[RCM_S_CHRG].qn   = chrg_y;

        res_d.vld = pipe_q[RCM_S_CHRG].vld;
        res_d.row = pipe_q[RCM_S_CHRG].row;
        res_d.col = pipe_q[RCM_S_CHRG].col;
        res_d.ir  = pipe_q[RCM_S_CHRG].ir;
        res_d.id  = pipe_q[RCM_S_CHRG].id;
        res_d.qn  = pipe_q[RCM_S_CHRG].qn;
        res_d.vn  = volt_y;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < NMID; k++) pipe_q[k] <= '0;
            res_q <= '0;
        end else begin
            for (int k = 0; k < NMID; k++) pipe_q[k] <= pipe_d[k];
            res_q <= res_d;
        end
    end

    assign out_valid_o = res_q.vld;
    assign out_row_o   = res_q.row;
    assign out_col_o   = res_q.col;
    assign i_right_o   = res_q.ir;
    assign i_down_o    = res_q.id;
    assign q_next_o    = res_q.qn;
    assign v_next_o    = res_q.vn;

endmodule

// File: rtl/rcmesh_node_pipe_chk.sv
module rcmesh_node_pipe_chk #(
    parameter int NUM_ROWS = 64,
    parameter int NUM_COLS = 64,
    parameter int DATA_W   = 32,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     in_valid_i,
    input logic [ROW_W-1:0]         in_row_i,
    input logic [COL_W-1:0]         in_col_i,
    input logic                     out_valid_o,
    input logic [ROW_W-1:0]         out_row_o,
    input logic [COL_W-1:0]         out_col_o,
    input logic signed [DATA_W-1:0] i_right_o,
    input logic signed [DATA_W-1:0] i_down_o
);
    logic [3:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              warm_cnt <= '0;
        else if (warm_cnt != 4'd8) warm_cnt <= warm_cnt + 4'd1;
    end
    assign warm = (warm_cnt == 4'd8);

    // R1 and R10: valid emerges exactly eight edges after entry
    p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm |-> (out_valid_o == $past(in_valid_i, 8)));

    // R1: indices travel with the node
    p_tag_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm && out_valid_o) |->
            (out_row_o == $past(in_row_i, 8) && out_col_o == $past(in_col_i, 8)));

    // R4: no current crosses the open right side
    p_right_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_col_o == COL_W'(NUM_COLS - 1)) |-> (i_right_o == '0));

    // R4: no current crosses the open bottom side
    p_down_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_row_o == ROW_W'(NUM_ROWS - 1)) |-> (i_down_o == '0));

endmodule

bind rcmesh_node_pipe rcmesh_node_pipe_chk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_row_i    (in_row_i),
    .in_col_i    (in_col_i),
    .out_valid_o (out_valid_o),
    .out_row_o   (out_row_o),
    .out_col_o   (out_col_o),
    .i_right_o   (i_right_o),
    .i_down_o    (i_down_o)
);

// File: tb/rcmesh_node_pipe_tb.sv
module rcmesh_node_pipe_tb;
    localparam int NR = 3;
    localparam int NC = 4;
    localparam int RW = 2;
    localparam int CW = 2;
    localparam longint DT = 419430;
    localparam longint FXMAX = 64'sd2147483647;
    localparam longint FXMIN = -64'sd2147483648;
    localparam int NPAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic [RW-1:0]        in_row = '0;
    logic [CW-1:0]        in_col = '0;
    logic signed [31:0]   v_s = '0, v_r = '0, v_d = '0, q_p = '0;
    logic signed [31:0]   g_r = '0, g_d = '0, z_c = '0, i_ld = '0;
    logic signed [31:0]   i_lf = '0, i_up = '0;
    logic                 out_valid;
    logic [RW-1:0]        out_row;
    logic [CW-1:0]        out_col;
    logic signed [31:0]   o_ir, o_id, o_q, o_v;

    rcmesh_node_pipe #(
        .NUM_ROWS (NR), .NUM_COLS (NC), .DATA_W (32), .FRAC_W (22),
        .DT_FX    (32'sd419430)
    ) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid),
        .in_row_i (in_row), .in_col_i (in_col),
        .v_self_i (v_s), .v_right_i (v_r), .v_down_i (v_d), .q_prev_i (q_p),
        .g_right_i (g_r), .g_down_i (g_d), .inv_cap_i (z_c), .i_load_i (i_ld),
        .i_left_in_i (i_lf), .i_up_in_i (i_up),
        .out_valid_o (out_valid), .out_row_o (out_row), .out_col_o (out_col),
        .i_right_o (o_ir), .i_down_o (o_id), .q_next_o (o_q), .v_next_o (o_v)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit valid_hist [0:4095];
    int unsigned seed = 32'h1234_5678;

    longint exp_ir [0:255];
    longint exp_id [0:255];
    longint exp_q  [0:255];
    longint exp_v  [0:255];
    int     exp_row [0:255];
    int     exp_col [0:255];
    int     exp_cyc [0:255];
    string  tag_ir [0:255];
    string  tag_id [0:255];
    string  tag_q  [0:255];
    string  tag_v  [0:255];
    int wr_idx = 0;
    int rd_idx = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint sat(input longint x);
        if (x > FXMAX) return FXMAX;
        if (x < FXMIN) return FXMIN;
        return x;
    endfunction

    function automatic longint mulsh(input longint a, input longint b);
        return sat((a * b) >>> 22);
    endfunction

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && cyc >= 8 && !finished) begin
            chk("R10 valid slot", longint'(out_valid), longint'(valid_hist[cyc-8]));
            if (out_valid) begin
                if (rd_idx >= wr_idx) begin
                    chk("R10 extra result", 1, 0);
                end else begin
                    chk("R1 latency", longint'(cyc), longint'(exp_cyc[rd_idx]));
                    chk("R1 row", longint'(out_row), longint'(exp_row[rd_idx]));
                    chk("R1 col", longint'(out_col), longint'(exp_col[rd_idx]));
                    chk(tag_ir[rd_idx], longint'(o_ir), exp_ir[rd_idx]);
                    chk(tag_id[rd_idx], longint'(o_id), exp_id[rd_idx]);
                    chk(tag_q[rd_idx],  longint'(o_q),  exp_q[rd_idx]);
                    chk(tag_v[rd_idx],  longint'(o_v),  exp_v[rd_idx]);
                    rd_idx++;
                end
            end
        end
    end

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        valid_hist[cyc] = 1'b0;
    endtask

    task automatic issue(input int pat, input int r, input int c);
        longint v, vr, vd, q, gr, gd, z, ld, il, iu;
        longint vr_e, vd_e, il_e, iu_e, dr, dd, ir, id, net, n2, dq, qn, vn;
        case (pat)
            0: begin
                v = 64'sd4194304; vr = v; vd = v; q = 64'sd3145728;
                gr = 64'sd4194304; gd = gr; z = 64'sd2097152; ld = 0; il = 0; iu = 0;
            end
            1: begin
                v  = (longint'(r * NC + c) <<< 20) + 64'sd4194304;
                vr = v - (longint'(c + 1) <<< 19);
                vd = v + (longint'(r + 1) <<< 18);
                gr = 64'sd4194304 + (longint'(c) <<< 20);
                gd = 64'sd2097152;
                il = longint'(c + 1) <<< 16;
                iu = -(longint'(r + 1) <<< 15);
                ld = 64'sd131072;
                q  = longint'(r * NC + c) <<< 20;
                z  = longint'(r + 1) <<< 20;
            end
            2: begin
                v  = longint'(int'(lcg())) >>> 5;
                vr = longint'(int'(lcg())) >>> 5;
                vd = longint'(int'(lcg())) >>> 5;
                q  = longint'(int'(lcg())) >>> 4;
                gr = longint'(lcg() & 32'h00FF_FFFF);
                gd = longint'(lcg() & 32'h00FF_FFFF);
                z  = longint'(lcg() & 32'h00FF_FFFF);
                ld = longint'(int'(lcg())) >>> 6;
                il = longint'(int'(lcg())) >>> 6;
                iu = longint'(int'(lcg())) >>> 6;
            end
            3: begin
                v = FXMAX - 5; vr = FXMIN + 7; vd = FXMIN;
                gr = 64'sd1073741824; gd = gr; il = FXMAX; iu = FXMAX;
                ld = FXMIN; q = FXMAX - 100; z = 64'sd536870912;
            end
            default: begin
                v = FXMIN; vr = FXMAX; vd = FXMAX - 3;
                gr = 64'sd268435456; gd = gr; il = FXMIN; iu = FXMIN;
                ld = FXMAX; q = FXMIN + 9; z = 64'sd1073741824;
            end
        endcase

        // independent model of the requirements (R2..R8)
        vr_e = (c == NC - 1) ? v : vr;
        vd_e = (r == NR - 1) ? v : vd;
        il_e = (c == 0) ? 0 : il;
        iu_e = (r == 0) ? 0 : iu;
        dr  = sat(v - vr_e);
        dd  = sat(v - vd_e);
        ir  = mulsh(dr, gr);
        id  = mulsh(dd, gd);
        net = sat(il_e + iu_e - ir - id);
        n2  = sat(net - ld);
        dq  = mulsh(n2, DT);
        qn  = sat(q + dq);
        vn  = mulsh(qn, z);

        @(negedge clk);
        in_valid = 1'b1;
        in_row = RW'(r);
        in_col = CW'(c);
        v_s = 32'(v); v_r = 32'(vr); v_d = 32'(vd); q_p = 32'(q);
        g_r = 32'(gr); g_d = 32'(gd); z_c = 32'(z); i_ld = 32'(ld);
        i_lf = 32'(il); i_up = 32'(iu);
        valid_hist[cyc] = 1'b1;

        exp_ir[wr_idx]  = ir;
        exp_id[wr_idx]  = id;
        exp_q[wr_idx]   = qn;
        exp_v[wr_idx]   = vn;
        exp_row[wr_idx] = r;
        exp_col[wr_idx] = c;
        exp_cyc[wr_idx] = cyc + 8;
        tag_ir[wr_idx]  = (c == NC - 1) ? "R4 right edge" : (pat >= 3 ? "R8 right sat" : "R2 right current");
        tag_id[wr_idx]  = (r == NR - 1) ? "R4 bottom edge" : (pat >= 3 ? "R8 down sat" : "R3 down current");
        tag_q[wr_idx]   = (pat >= 3) ? "R8 charge sat" : ((c == 0 || r == 0) ? "R5 edge inflow charge" : "R6 charge");
        tag_v[wr_idx]   = (pat >= 3) ? "R8 voltage sat" : "R7 voltage";
        wr_idx++;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) valid_hist[i] = 1'b0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 reset valid", longint'(out_valid), 0);
        chk("R9 reset charge", longint'(o_q), 0);
        chk("R9 reset voltage", longint'(o_v), 0);
        chk("R9 reset current", longint'(o_ir) + longint'(o_id), 0);
        rst_n = 1'b1;
        bubble();
        for (int p = 0; p < NPAT; p++) begin
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    issue(p, r, c);
            bubble();
            bubble();
        end
        repeat (12) bubble();
        chk("R10 result count", longint'(rd_idx), longint'(wr_idx));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", rd_idx, wr_idx);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule